// File: doc/BRIEF.md
# Priority Event Buffer Manager

This block sits in one readout channel, between a raw sample pipeline and the board-level arbiter. When a delayed local trigger and a global trigger arrive in the same cycle, it claims a free slot out of four 32-word event buffers and fills it one word per clock. Each frame starts with a three-word header: a 32-bit spill-relative time stamp split over two words, then the channel and board identifiers. The remaining 29 words are data taken from the raw pipeline. A second capture may start while a first one is still running, but only once the running one is far enough along. At most two captures run at the same time.

Each buffer carries a small priority that grows as newer captures arrive. The channel reports the largest priority upward on every clock. When the arbiter grants a read, the oldest pending frame is streamed out. Streaming may begin before the frame is complete, and the output simply waits for words that have not been written yet. A spill-switch request restarts the time base and marks up to two pending frames as critical, so the arbiter drains them before the spill boundary closes.

Top module: `evbuf_mgr`

## Requirements
- R1: A capture starts only on a clock edge where `local_trig` and `global_trig` are both high. Either trigger alone has no effect.
- R2: A frame holds 32 words, read in this order: word 0 is stamp[31:16] and word 1 is stamp[15:0]. Word 2 is {board_id[11:0], ch_id[3:0]}. Word k, for k from 3 to 31, is the `raw_data` value present at the (k+1)-th clock edge after the accepting edge.
- R3: The internal time base becomes 0 at the edge that sees `spill_req`. It then rises by 1 each clock and holds at `TIME_MAX`. The stamp is the time-base value at the accepting edge.
- R4: An accepted capture goes into the lowest-index buffer whose priority is 0 and which is neither being written nor being read. That buffer's priority becomes 1. Every other priority in the range 1 to 3 rises by 1, and priorities of 4 or more are unchanged.
- R5: With one capture running, a coincidence is accepted only if that capture has already written more than 16 words. With two captures running, a coincidence is ignored and does not count as an overflow.
- R6: A coincidence that passes the R5 rule but finds no free buffer is dropped and sets `overflow`. Only reset clears `overflow`.
- R7: A `rd_grant` while no read is active and `prio_max` is non-zero starts a read of the buffer with the highest priority, the lowest index winning a tie. That buffer's priority becomes 0 at the start of the read.
- R8: A read delivers the frame's 32 words in order, one per `rd_valid` cycle, with `rd_last` on the 32nd word. A word is never delivered before it has been written, so `rd_valid` stays low while the read waits for the write.
- R9: A buffer being read is not claimed by a new capture until its read has finished, so a capture during a read goes to another buffer and both frames arrive intact.
- R10: On `spill_req`, the two lowest-index buffers whose priority is between 1 and 4 have 5 added to it. If fewer than two qualify, only those are raised. `crit` is high while any priority is 5 or more.
- R11: `prio_max` equals the largest buffer priority on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| local_trig | input | 1 | Channel trigger, already delayed to line up with the global decision |
| global_trig | input | 1 | Global trigger decision |
| spill_req | input | 1 | Spill-switch request: restarts the time base and promotes pending frames |
| raw_data | input | 16 | Sample stream from the raw pipeline |
| ch_id | input | 4 | Channel identifier for the header |
| board_id | input | 12 | Board identifier for the header |
| rd_grant | input | 1 | Read grant from the board arbiter |
| prio_max | output | 4 | Highest buffer priority in the channel |
| crit | output | 1 | At least one buffer holds a critical frame |
| overflow | output | 1 | Sticky: a capture was lost for lack of a buffer |
| rd_valid | output | 1 | `rd_data` holds a frame word |
| rd_data | output | 16 | Frame word being streamed out |
| rd_last | output | 1 | Last word of the frame |

## Verification
The bound checker watches the invariants on every cycle:
- every capture start follows a trigger coincidence and lands on a zero-priority buffer that then reads 1;
- no more than two buffers are being written at once;
- the read pointer never runs ahead of the write count of its buffer;
- a read start leaves the chosen buffer at priority 0;
- `crit` only rises after a spill request;
- `overflow` never falls;
- no priority exceeds `prio_max`.

Only the bench scenarios can show the rest:
- frame contents and time stamps, including a time base that saturates;
- the 16-word retrigger window and its two-writer limit;
- oldest-first read order and the choice of which buffers get promoted;
- a read that starts right behind its write, with a second capture arriving during that read.

// File: rtl/evbuf_pkg.sv
package evbuf_pkg;
    localparam int NBUF       = 4;
    localparam int WORDS      = 32;
    localparam int DW         = 16;
    localparam int HDR        = 3;
    localparam int PW         = 4;
    localparam int AGE_MAX    = 4;
    localparam int CRIT_ADD   = 5;
    localparam int CRIT_LIMIT = 2;
    localparam int GATE_MIN   = 16;
    localparam int CH_W       = 4;
    localparam int BD_W       = 12;
    localparam int STAMP_W    = 32;

    localparam int AW = $clog2(WORDS);
    localparam int CW = $clog2(WORDS + 1);
    localparam int IW = $clog2(NBUF);

    typedef logic [PW-1:0] prio_t;
    typedef logic [DW-1:0] word_t;
    typedef logic [CW-1:0] cnt_t;
    typedef logic [IW-1:0] idx_t;

    typedef struct packed {
        logic [STAMP_W-1:0] stamp;
        logic [BD_W-1:0]    board;
        logic [CH_W-1:0]    ch;
    } hdr_t;

    // header word k of a frame
    function automatic word_t hdr_word(hdr_t h, cnt_t k);
        case (k)
            CW'(0):  return h.stamp[STAMP_W-1:STAMP_W-DW];
            CW'(1):  return h.stamp[DW-1:0];
            default: return {h.board, h.ch};
        endcase
    endfunction

    function automatic logic is_pending(prio_t p);
        return (p != '0) && (p <= PW'(AGE_MAX));
    endfunction

    // aging step applied on every accepted capture
    function automatic prio_t age(prio_t p);
        if (p != '0 && p < PW'(AGE_MAX)) return p + PW'(1);
        return p;
    endfunction
endpackage

// File: rtl/evbuf_slot.sv
module evbuf_slot
    import evbuf_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  hdr_t          hdr_in,
    input  word_t         raw_data,
    input  logic [AW-1:0] rd_addr,
    output word_t         rd_word,
    output cnt_t          wr_cnt,
    output logic          writing
);
    word_t mem [WORDS];
    hdr_t  hdr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            writing <= 1'b0;
            wr_cnt  <= '0;
            hdr_q   <= '0;
        end else if (start) begin
            writing <= 1'b1;
            wr_cnt  <= '0;
            hdr_q   <= hdr_in;
        end else if (writing) begin
            wr_cnt <= wr_cnt + CW'(1);
            if (wr_cnt == CW'(WORDS - 1)) writing <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (writing && !start)
            mem[wr_cnt[AW-1:0]] <= (wr_cnt < CW'(HDR)) ? hdr_word(hdr_q, wr_cnt) : raw_data;
    end

    assign rd_word = mem[rd_addr];
endmodule

// File: rtl/evbuf_prio.sv
module evbuf_prio
    import evbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NBUF-1:0]   claim,
    input  logic              age_en,
    input  logic [NBUF-1:0]   take,
    input  logic              spill_req,
    output prio_t [NBUF-1:0]  prio,
    output prio_t             prio_max,
    output idx_t              best,
    output logic              crit
);
    logic [NBUF-1:0]  promote;
    prio_t [NBUF-1:0] nxt;

    always_comb begin : pick_promote
        int n;
        n = 0;
        promote = '0;
        for (int i = 0; i < NBUF; i++) begin
            if (spill_req && n < CRIT_LIMIT && is_pending(prio[i]) && !take[i]) begin
                promote[i] = 1'b1;
                n++;
            end
        end
    end

    always_comb begin
        for (int i = 0; i < NBUF; i++) begin
            if (take[i])         nxt[i] = '0;
            else if (claim[i])   nxt[i] = PW'(1);
            else if (promote[i]) nxt[i] = prio[i] + PW'(CRIT_ADD);
            else if (age_en)     nxt[i] = age(prio[i]);
            else                 nxt[i] = prio[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) prio <= '0;
        else     prio <= nxt;
    end

    always_comb begin
        prio_max = '0;
        best     = '0;
        crit     = 1'b0;
        for (int i = 0; i < NBUF; i++) begin
            if (prio[i] > prio_max) begin
                prio_max = prio[i];
                best     = IW'(i);
            end
            if (prio[i] >= PW'(CRIT_ADD)) crit = 1'b1;
        end
    end
endmodule

// File: rtl/evbuf_reader.sv
module evbuf_reader
    import evbuf_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  idx_t          start_idx,
    input  cnt_t          sel_cnt,
    input  word_t         sel_word,
    output logic          reading,
    output idx_t          rd_idx,
    output cnt_t          rd_ptr,
    output logic [AW-1:0] rd_addr,
    output logic          rd_valid,
    output word_t         rd_data,
    output logic          rd_last
);
    always_ff @(posedge clk) begin
        if (rst) begin
            reading  <= 1'b0;
            rd_idx   <= '0;
            rd_ptr   <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
            rd_last  <= 1'b0;
        end else begin
            rd_valid <= 1'b0;
            rd_last  <= 1'b0;
            if (start) begin
                reading <= 1'b1;
                rd_idx  <= start_idx;
                rd_ptr  <= '0;
            end else if (reading && rd_ptr < sel_cnt) begin
                rd_valid <= 1'b1;
                rd_data  <= sel_word;
                rd_last  <= (rd_ptr == CW'(WORDS - 1));
                rd_ptr   <= rd_ptr + CW'(1);
                if (rd_ptr == CW'(WORDS - 1)) reading <= 1'b0;
            end
        end
    end

    assign rd_addr = rd_ptr[AW-1:0];
endmodule

// File: rtl/evbuf_mgr.sv
module evbuf_mgr
    import evbuf_pkg::*;
#(
    parameter int TIME_MAX = 1250000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             local_trig,
    input  logic             global_trig,
    input  logic             spill_req,
    input  logic [DW-1:0]    raw_data,
    input  logic [CH_W-1:0]  ch_id,
    input  logic [BD_W-1:0]  board_id,
    input  logic             rd_grant,
    output logic [PW-1:0]    prio_max,
    output logic             crit,
    output logic             overflow,
    output logic             rd_valid,
    output logic [DW-1:0]    rd_data,
    output logic             rd_last
);
    localparam int TW = $clog2(TIME_MAX + 1);

    logic [TW-1:0]    timer;
    hdr_t             hdr_in;
    prio_t [NBUF-1:0] prio;
    idx_t             best;
    word_t            slot_word [NBUF];
    cnt_t             slot_cnt  [NBUF];
    logic [NBUF-1:0]  writing, free_v, claim, take;
    logic             reading, coin, gate_ok, any_free, accept, rd_start;
    idx_t             rd_idx;
    cnt_t             rd_ptr, lead_cnt, sel_cnt;
    logic [AW-1:0]    rd_addr;
    word_t            sel_word;

    always_ff @(posedge clk) begin
        if (rst || spill_req)          timer <= '0;
        else if (timer < TW'(TIME_MAX)) timer <= timer + TW'(1);
    end

    assign hdr_in = '{stamp: STAMP_W'(timer), board: board_id, ch: ch_id};
    assign coin   = local_trig && global_trig;

    always_comb begin
        lead_cnt = '0;
        claim    = '0;
        any_free = 1'b0;
        for (int i = 0; i < NBUF; i++) begin
            if (writing[i]) lead_cnt = lead_cnt | slot_cnt[i];
            free_v[i] = (prio[i] == '0) && !writing[i] && !(reading && rd_idx == IW'(i));
            if (free_v[i] && !any_free) begin
                claim[i] = 1'b1;
                any_free = 1'b1;
            end
        end
    end

    assign gate_ok = ($countones(writing) == 0) ||
                     ($countones(writing) == 1 && lead_cnt > CW'(GATE_MIN));
    assign accept   = coin && gate_ok && any_free;
    assign rd_start = rd_grant && !reading && (prio_max != '0);
    assign take     = rd_start ? (NBUF'(1) << best) : '0;

    always_ff @(posedge clk) begin
        if (rst)                              overflow <= 1'b0;
        else if (coin && gate_ok && !any_free) overflow <= 1'b1;
    end

    evbuf_prio u_prio (
        .clk(clk), .rst(rst), .claim(accept ? claim : '0), .age_en(accept),
        .take(take), .spill_req(spill_req), .prio(prio), .prio_max(prio_max),
        .best(best), .crit(crit)
    );

    for (genvar g = 0; g < NBUF; g++) begin : g_slot
        evbuf_slot u_slot (
            .clk(clk), .rst(rst), .start(accept && claim[g]), .hdr_in(hdr_in),
            .raw_data(raw_data), .rd_addr(rd_addr), .rd_word(slot_word[g]),
            .wr_cnt(slot_cnt[g]), .writing(writing[g])
        );
    end

    assign sel_cnt  = slot_cnt[rd_idx];
    assign sel_word = slot_word[rd_idx];

    evbuf_reader u_rd (
        .clk(clk), .rst(rst), .start(rd_start), .start_idx(best),
        .sel_cnt(sel_cnt), .sel_word(sel_word), .reading(reading),
        .rd_idx(rd_idx), .rd_ptr(rd_ptr), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_last(rd_last)
    );
endmodule

// File: rtl/evbuf_chk.sv
module evbuf_chk
    import evbuf_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             local_trig,
    input logic             global_trig,
    input logic             spill_req,
    input prio_t [NBUF-1:0] prio,
    input prio_t            prio_max,
    input logic             crit,
    input logic             overflow,
    input logic [NBUF-1:0]  writing,
    input logic             reading,
    input idx_t             rd_idx,
    input cnt_t             rd_ptr,
    input cnt_t             sel_cnt,
    input logic             rd_start,
    input logic             rd_valid,
    input logic             rd_last
);
    for (genvar g = 0; g < NBUF; g++) begin : g_each
        p_coin_start_r1: assert property (@(posedge clk) disable iff (rst)
            $rose(writing[g]) |-> $past(local_trig && global_trig));
        p_claim_zero_r4: assert property (@(posedge clk) disable iff (rst)
            $rose(writing[g]) |-> (prio[g] == PW'(1) && $past(prio[g]) == '0));
        p_max_cover_r11: assert property (@(posedge clk) disable iff (rst)
            prio[g] <= prio_max);
    end

    p_two_writers_r5: assert property (@(posedge clk) disable iff (rst)
        $countones(writing) <= 2);
    p_no_overflow_fall_r6: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);
    p_take_clears_r7: assert property (@(posedge clk) disable iff (rst)
        rd_start |=> prio[rd_idx] == '0);
    p_no_pass_r8: assert property (@(posedge clk) disable iff (rst)
        reading |-> rd_ptr <= sel_cnt);
    p_last_valid_r8: assert property (@(posedge clk) disable iff (rst)
        rd_last |-> rd_valid);
    p_crit_source_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(crit) |-> $past(spill_req));
endmodule

bind evbuf_mgr evbuf_chk u_chk (
    .clk(clk), .rst(rst), .local_trig(local_trig), .global_trig(global_trig),
    .spill_req(spill_req), .prio(prio), .prio_max(prio_max), .crit(crit),
    .overflow(overflow), .writing(writing), .reading(reading), .rd_idx(rd_idx),
    .rd_ptr(rd_ptr), .sel_cnt(sel_cnt), .rd_start(rd_start),
    .rd_valid(rd_valid), .rd_last(rd_last)
);

// File: tb/tb_evbuf_mgr.sv
module tb_evbuf_mgr;
    localparam int TMAX = 100;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        local_trig = 1'b0, global_trig = 1'b0, spill_req = 1'b0, rd_grant = 1'b0;
    logic [15:0] raw_data = '0;
    logic [3:0]  prio_max;
    logic        crit, overflow, rd_valid, rd_last;
    logic [15:0] rd_data;

    int errors = 0, checks = 0, tick = 0;
    int got_n, last_pos;
    logic [15:0] got [32];
    bit done = 0;

    always #4 clk = ~clk;

    evbuf_mgr #(.TIME_MAX(TMAX)) dut (
        .clk(clk), .rst(rst), .local_trig(local_trig), .global_trig(global_trig),
        .spill_req(spill_req), .raw_data(raw_data), .ch_id(4'd9), .board_id(12'd345),
        .rd_grant(rd_grant), .prio_max(prio_max), .crit(crit), .overflow(overflow),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_last(rd_last)
    );

    always @(posedge clk) begin
        #2;
        tick++;
        raw_data = 16'(tick);
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic trig(logic lt, logic gt, output int m);
        @(negedge clk);
        local_trig = lt; global_trig = gt; m = tick;
        @(negedge clk);
        local_trig = 0; global_trig = 0;
    endtask

    task automatic spill(output int s);
        @(negedge clk);
        spill_req = 1; s = tick;
        @(negedge clk);
        spill_req = 0;
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic read_one();
        got_n = 0; last_pos = -1;
        @(negedge clk) rd_grant = 1;
        @(negedge clk) rd_grant = 0;
        for (int c = 0; c < 200 && got_n < 32; c++) begin
            if (rd_valid) begin
                got[got_n] = rd_data;
                if (rd_last) last_pos = got_n;
                got_n++;
            end
            if (got_n < 32) @(negedge clk);
        end
    endtask

    // R2/R3: expected frame from trigger tick m and spill tick s
    task automatic check_frame(string req, int m, int s);
        int st, bad;
        logic [15:0] e;
        st = (m - s - 1 > TMAX) ? TMAX : m - s - 1;
        bad = -1;
        for (int k = 0; k < 32; k++) begin
            if (k == 0)      e = 16'(st >> 16);
            else if (k == 1) e = 16'(st);
            else if (k == 2) e = {12'd345, 4'd9};
            else             e = 16'(m + 1 + k);
            if (bad < 0 && (k >= got_n || got[k] !== e)) begin
                bad = k;
                errors++;
                $display("FAIL %s: word %0d actual=%0d expected=%0d", req, k,
                         (k < got_n) ? int'(got[k]) : -1, e);
            end
        end
        checks++;
        chk("R8 rd_last position", last_pos, 31);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int s0, s2, ma, mb, mc, md, me, mx;
        wait_cyc(4);
        rst = 0;
        @(negedge clk);
        chk("R11 reset prio_max", prio_max, 0);
        chk("R10 reset crit", crit, 0);
        chk("R6 reset overflow", overflow, 0);
        chk("R8 reset rd_valid", rd_valid, 0);

        // R1: single triggers, then coincidence; R2/R3 frame content
        spill(s0);
        wait_cyc(3);
        trig(1, 0, mx); chk("R1 local alone", prio_max, 0);
        trig(0, 1, mx); chk("R1 global alone", prio_max, 0);
        trig(1, 1, ma); chk("R4 claim gives 1", prio_max, 1);
        wait_cyc(40);
        read_one();
        check_frame("R2 R3 frame", ma, s0);
        chk("R7 prio cleared", prio_max, 0);

        // R5: retrigger window
        trig(1, 1, ma);
        wait_cyc(8);
        trig(1, 1, mx); chk("R5 early retrigger ignored", prio_max, 1);
        wait_cyc(7);
        trig(1, 1, mb); chk("R5 retrigger after 16 words, R4 aging", prio_max, 2);
        trig(1, 1, mx); chk("R5 third while two writing", prio_max, 2);
        chk("R5 no overflow", overflow, 0);
        wait_cyc(40);
        read_one(); check_frame("R7 oldest first", ma, s0);
        read_one(); check_frame("R2 overlapping capture", mb, s0);

        // R8/R9: read right behind write, capture during read
        trig(1, 1, mc);
        fork
            read_one();
            begin wait_cyc(18); trig(1, 1, md); end
        join
        check_frame("R8 read behind write", mc, s0);
        chk("R9 capture during read kept", prio_max, 1);
        wait_cyc(40);
        read_one(); check_frame("R9 second frame intact", md, s0);

        // R4/R6/R7: fill all four, overflow, read order
        trig(1, 1, ma); wait_cyc(40);
        trig(1, 1, mb); wait_cyc(40);
        trig(1, 1, mc); chk("R4 three aged", prio_max, 3);
        wait_cyc(40);
        trig(1, 1, md); chk("R4 four aged", prio_max, 4);
        chk("R6 no overflow yet", overflow, 0);
        wait_cyc(40);
        trig(1, 1, me); chk("R6 overflow set", overflow, 1);
        chk("R6 dropped capture leaves prios", prio_max, 4);
        read_one(); check_frame("R7 order A", ma, s0);
        read_one(); check_frame("R7 order B", mb, s0);
        read_one(); check_frame("R7 order C", mc, s0);
        read_one(); check_frame("R7 order D", md, s0);
        chk("R6 overflow sticky", overflow, 1);

        // R10/R3: spill promotion and time base restart
        spill(s0);
        trig(1, 1, ma); wait_cyc(40);
        trig(1, 1, mb); wait_cyc(40);
        trig(1, 1, mc); wait_cyc(40);
        chk("R10 no crit before spill", crit, 0);
        spill(s2);
        chk("R10 promoted max", prio_max, 8);
        chk("R10 crit raised", crit, 1);
        read_one(); check_frame("R10 first critical", ma, s0);
        chk("R10 crit held", crit, 1);
        read_one(); check_frame("R10 second critical", mb, s0);
        chk("R10 crit cleared", crit, 0);
        chk("R10 third not promoted", prio_max, 1);
        read_one(); check_frame("R3 old spill stamp", mc, s0);
        wait_cyc(5);
        trig(1, 1, me);
        wait_cyc(40);
        read_one(); check_frame("R3 stamp after spill", me, s2);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule